// File: doc/BRIEF.md
# Translation Cache with Global Entries

This block is a small, fully associative cache of virtual-to-physical page translations that a page walker fills after each completed walk. A lookup presents a virtual page number (virtual address bits 31..12) and, in the same cycle, gets back a hit flag, the physical page number, the page size of the matching entry and its attribute bits. Entries of two sizes share one array: a small entry covers one 4 KB page, and a large entry covers a 4 MB region and is compared on the upper ten bits of the page number only.

Two controls remove entries. A root-table write clears every entry that is not marked global in one cycle. A single-page invalidate removes only the entry whose region contains the given page number, global or not. When the array is full, fills displace entries in round-robin order. A fill always takes a free slot first, and it always replaces an entry that already covers the same page, so no address ever hits two entries.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset, no lookup hits.
- R2: A small entry (size flag 0) hits only when all 20 bits of the lookup page number equal its tag. It returns its stored 20-bit frame, size flag 0, and its 6 attribute bits: bit 5 read/write, bit 4 user, bit 3 cache-disable, bit 2 write-through, bit 1 dirty, bit 0 global.
- R3: The lookup is combinational on the lookup page number. A fill does not change the lookup result until the next rising clock edge.
- R4: A large entry (size flag 1) hits when page-number bits 19..10 equal its tag. The returned frame takes bits 19..10 from the entry and bits 9..0 from the lookup page number, with size flag 1.
- R5: A root-table write clears every entry whose global attribute bit 0 is 0 at the next edge and leaves global entries valid.
- R6: A single-page invalidate removes the entry that the given page number would hit, including a global or large entry, and leaves every other entry valid.
- R7: A fill whose region overlaps one or more valid entries (same bits 19..10, and either side large or bits 9..0 equal) replaces them, so at most one entry ever hits.
- R8: In a cycle where an invalidate or a root-table write is asserted, a fill is ignored.
- R9: When all 16 entries are valid and the fill overlaps none of them, the fill evicts the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only on such evictions.
- R10: A fill that overlaps no entry goes to the lowest-numbered invalid slot if any slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | 20 | Lookup virtual page number (VA bits 31..12) |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_pfn | output | 20 | Physical page number for the lookup |
| lk_large | output | 1 | Matching entry is a 4 MB entry |
| lk_attr | output | 6 | Attribute bits of the matching entry |
| fill_en | input | 1 | Write a new translation |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pfn | input | 20 | Physical frame of the fill |
| fill_large | input | 1 | Fill is a 4 MB entry |
| fill_attr | input | 6 | Attribute bits of the fill |
| root_wr | input | 1 | Root-table write: flush non-global entries |
| inv_en | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
The bench looks up an address inside a large region away from its base. A design that compared the full tag on large entries would miss there, and one that took the low frame bits from the entry would return the wrong frame. It fills a large entry over several small ones in the same region, where a missing overlap clear would leave two entries hitting and OR their frames together. It flushes with a global entry present and then invalidates that global entry directly. It drives a fill in the same cycle as an invalidate or a flush, so that giving the fill priority would show up as a stray hit. Finally it fills the array past capacity and punches a hole in it, which exposes a pointer that does not start at 0, advances on non-evicting fills, or evicts while a free slot exists.

// File: rtl/xlat_cache_pkg.sv
`timescale 1ns/1ps
// Shared types for the translation cache.
package xlat_cache_pkg;
    // Attribute bits held per entry; the packed order fixes the port bit positions.
    typedef struct packed {
        logic rw;
        logic usr;
        logic cd;
        logic wt;
        logic dirty;
        logic glob;
    } xattr_t;

    localparam int ATTR_W = $bits(xattr_t);
endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
// Tag comparator for one entry.
// Compares the upper HI_W bits always, and the lower bits only when neither
// the entry is large nor the caller asks for a wide (region) compare.
// Assumes VPN_W > HI_W.
module xlat_match #(
    parameter int VPN_W = 20,
    parameter int HI_W  = 10
) (
    input  logic             ent_valid,
    input  logic             ent_large,
    input  logic             wide,
    input  logic [VPN_W-1:0] ent_tag,
    input  logic [VPN_W-1:0] probe,
    output logic             hit
);
    localparam int LO_W = VPN_W - HI_W;

    logic hi_eq;
    logic lo_eq;

    // Region compare on the upper bits, page compare on the lower bits.
    assign hi_eq = (ent_tag[VPN_W-1 -: HI_W] == probe[VPN_W-1 -: HI_W]);
    assign lo_eq = (ent_tag[LO_W-1:0] == probe[LO_W-1:0]);
    assign hit   = ent_valid & hi_eq & (ent_large | wide | lo_eq);
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
// Slot chooser for fills.
// Priority: lowest overlapping slot, then lowest invalid slot, then the
// round-robin pointer. The pointer moves only when a valid entry is evicted.
// Assumes fill_go is already qualified against invalidate and flush.
module xlat_victim #(
    parameter  int ENTRIES = 16,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] overlap,
    output logic [IDX_W-1:0]   slot
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] ov_idx;
    logic [IDX_W-1:0] free_idx;
    logic             ov_any;
    logic             free_any;
    logic             evict;

    // Find the lowest overlapping slot and the lowest free slot.
    always_comb begin
        ov_idx   = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (overlap[i]) ov_idx = IDX_W'(i);
            if (!valid[i])  free_idx = IDX_W'(i);
        end
    end

    assign ov_any   = |overlap;
    assign free_any = ~&valid;
    assign evict    = fill_go & ~ov_any & ~free_any;
    assign slot     = ov_any ? ov_idx : (free_any ? free_idx : rr_q);

    // Round-robin pointer: advance with wrap on each eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (evict) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
// Fully associative translation cache with global entries and two page sizes.
// Lookup is combinational; fill, flush and single-page invalidate act at the
// next clock edge, with flush/invalidate taking precedence over a fill.
// Assumes the filler never relies on a fill being accepted in a cycle with
// root_wr or inv_en asserted.
module xlat_cache #(
    parameter  int VPN_W   = 20,
    parameter  int LARGE_W = 10,
    parameter  int ENTRIES = 16,
    localparam int ATTR_W  = xlat_cache_pkg::ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [VPN_W-1:0]  lk_pfn,
    output logic              lk_large,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [VPN_W-1:0]  fill_pfn,
    input  logic              fill_large,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              root_wr,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn
);
    import xlat_cache_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int LOW_W = VPN_W - LARGE_W;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] large_q;
    logic [VPN_W-1:0]   vtag_q [ENTRIES];
    logic [VPN_W-1:0]   ptag_q [ENTRIES];
    xattr_t             attr_q [ENTRIES];

    logic [ENTRIES-1:0] glob_vec;
    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] inv_vec;
    logic [ENTRIES-1:0] ov_vec;
    logic [ENTRIES-1:0] flush_mask;
    logic [ENTRIES-1:0] kill_mask;
    logic [ENTRIES-1:0] slot_oh;
    logic [IDX_W-1:0]   slot;
    logic               fill_go;

    logic [VPN_W-1:0]   sel_pfn;
    logic [ATTR_W-1:0]  sel_attr;
    logic               sel_large;

    // Per-entry comparators for lookup, invalidate and fill overlap.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign glob_vec[g] = attr_q[g].glob;

        xlat_match #(.VPN_W(VPN_W), .HI_W(LARGE_W)) u_lk (
            .ent_valid(valid_q[g]), .ent_large(large_q[g]), .wide(1'b0),
            .ent_tag(vtag_q[g]), .probe(lk_vpn), .hit(lk_vec[g])
        );
        xlat_match #(.VPN_W(VPN_W), .HI_W(LARGE_W)) u_inv (
            .ent_valid(valid_q[g]), .ent_large(large_q[g]), .wide(1'b0),
            .ent_tag(vtag_q[g]), .probe(inv_vpn), .hit(inv_vec[g])
        );
        xlat_match #(.VPN_W(VPN_W), .HI_W(LARGE_W)) u_ov (
            .ent_valid(valid_q[g]), .ent_large(large_q[g]), .wide(fill_large),
            .ent_tag(vtag_q[g]), .probe(fill_vpn), .hit(ov_vec[g])
        );
    end

    assign fill_go = fill_en & ~inv_en & ~root_wr;

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .fill_go(fill_go),
        .valid(valid_q), .overlap(ov_vec), .slot(slot)
    );

    // Select the matching entry's fields; overlap clearing keeps this one-hot.
    always_comb begin
        sel_pfn   = '0;
        sel_attr  = '0;
        sel_large = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_vec[i]) begin
                sel_pfn   = sel_pfn | ptag_q[i];
                sel_attr  = sel_attr | attr_q[i];
                sel_large = sel_large | large_q[i];
            end
        end
    end

    assign lk_hit   = |lk_vec;
    assign lk_large = sel_large;
    assign lk_attr  = sel_attr;
    assign lk_pfn   = sel_large ? {sel_pfn[VPN_W-1 -: LARGE_W], lk_vpn[LOW_W-1:0]}
                                : sel_pfn;

    // Removal masks for the flush and invalidate paths.
    always_comb begin
        flush_mask = root_wr ? ~glob_vec : {ENTRIES{1'b0}};
        kill_mask  = inv_en ? inv_vec : {ENTRIES{1'b0}};
        slot_oh    = {{(ENTRIES-1){1'b0}}, 1'b1} << slot;
    end

    // Valid bits: removals win over fills; a fill clears overlapping entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (root_wr || inv_en) begin
            valid_q <= valid_q & ~flush_mask & ~kill_mask;
        end else if (fill_go) begin
            valid_q <= (valid_q & ~ov_vec) | slot_oh;
        end
    end

    // Entry payload: written only by an accepted fill.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            vtag_q[slot]  <= fill_vpn;
            ptag_q[slot]  <= fill_pfn;
            large_q[slot] <= fill_large;
            attr_q[slot]  <= xattr_t'(fill_attr);
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
// Property checker for xlat_cache, attached by bind.
// Observes the valid, global, lookup-hit and invalidate-hit vectors.
module xlat_cache_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fill_en,
    input logic               root_wr,
    input logic               inv_en,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] glob_vec,
    input logic [ENTRIES-1:0] lk_vec,
    input logic [ENTRIES-1:0] inv_vec
);
    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec)); // R7

    AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (root_wr && !inv_en) |=> (valid_q == $past(valid_q & glob_vec))); // R5

    AST_INV_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> ((valid_q & $past(inv_vec)) == '0)); // R6

    AST_FILL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && (inv_en || root_wr)) |=>
            ($countones(valid_q) <= $countones($past(valid_q)))); // R8

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_en && !root_wr) |=> (valid_q != '0)); // R2
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .root_wr(root_wr),
    .inv_en(inv_en), .valid_q(valid_q), .glob_vec(glob_vec),
    .lk_vec(lk_vec), .inv_vec(inv_vec)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
// Directed bench for xlat_cache: one task per scenario.
module xlat_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] lk_vpn;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic        lk_large;
    logic [5:0]  lk_attr;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [19:0] fill_pfn;
    logic        fill_large;
    logic [5:0]  fill_attr;
    logic        root_wr;
    logic        inv_en;
    logic [19:0] inv_vpn;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_pfn(lk_pfn), .lk_large(lk_large), .lk_attr(lk_attr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_large(fill_large), .fill_attr(fill_attr), .root_wr(root_wr),
        .inv_en(inv_en), .inv_vpn(inv_vpn)
    );

    // Compare the current lookup outputs against expectations.
    task automatic compare(input string req, input logic [19:0] vpn, input logic eh,
                           input logic [19:0] ep, input logic el, input logic [5:0] ea);
        checks++;
        if (lk_hit !== eh || (eh && (lk_pfn !== ep || lk_large !== el || lk_attr !== ea))) begin
            errors++;
            $display("FAIL %s vpn=%h got hit=%b pfn=%h large=%b attr=%h exp hit=%b pfn=%h large=%b attr=%h",
                     req, vpn, lk_hit, lk_pfn, lk_large, lk_attr, eh, ep, el, ea);
        end
    endtask

    // Look up one page in the low clock phase.
    task automatic look(input string req, input logic [19:0] vpn, input logic eh,
                        input logic [19:0] ep, input logic el, input logic [5:0] ea);
        @(negedge clk);
        lk_vpn = vpn;
        #1;
        compare(req, vpn, eh, ep, el, ea);
    endtask

    // Drive one cycle of control; it takes effect at the following edge.
    task automatic op(input logic f, input logic iv, input logic fl,
                      input logic [19:0] v, input logic [19:0] p, input logic lg,
                      input logic [5:0] a, input logic [19:0] iva);
        @(negedge clk);
        fill_en = f; fill_vpn = v; fill_pfn = p; fill_large = lg; fill_attr = a;
        inv_en = iv; inv_vpn = iva; root_wr = fl;
        @(negedge clk);
        fill_en = 1'b0; inv_en = 1'b0; root_wr = 1'b0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic lg,
                        input logic [5:0] a);
        op(1'b1, 1'b0, 1'b0, v, p, lg, a, 20'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: empty after reset, including after earlier fills.
    task automatic t_reset();
        look("R1", 20'h00000, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R1", 20'h12345, 1'b0, 20'h0, 1'b0, 6'h0);
        fill(20'h12345, 20'hABCDE, 1'b0, 6'h20);
        do_reset();
        look("R1", 20'h12345, 1'b0, 20'h0, 1'b0, 6'h0);
    endtask

    // R2/R3: small entry exact match; fill invisible before the edge.
    task automatic t_small();
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h12345; fill_pfn = 20'hABCDE;
        fill_large = 1'b0; fill_attr = 6'h24;
        lk_vpn = 20'h12345;
        #1;
        compare("R3", 20'h12345, 1'b0, 20'h0, 1'b0, 6'h0);
        @(negedge clk);
        fill_en = 1'b0;
        #1;
        compare("R3", 20'h12345, 1'b1, 20'hABCDE, 1'b0, 6'h24);
        look("R2", 20'h12345, 1'b1, 20'hABCDE, 1'b0, 6'h24);
        look("R2", 20'h12346, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R2", 20'h92345, 1'b0, 20'h0, 1'b0, 6'h0);
    endtask

    // R4: large entry matches on upper bits, frame low bits from the address.
    task automatic t_large();
        fill(20'h80000, 20'h40000, 1'b1, 6'h30);
        look("R4", 20'h80123, 1'b1, 20'h40123, 1'b1, 6'h30);
        look("R4", 20'h803FF, 1'b1, 20'h403FF, 1'b1, 6'h30);
        look("R4", 20'h80400, 1'b0, 20'h0, 1'b0, 6'h0);
    endtask

    // R5/R6: flush spares globals; invalidate removes a global or large entry only.
    task automatic t_flush_inv();
        fill(20'h00100, 20'h00200, 1'b0, 6'h01);
        op(1'b0, 1'b0, 1'b1, 20'h0, 20'h0, 1'b0, 6'h0, 20'h0);
        look("R5", 20'h12345, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R5", 20'h80123, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R5", 20'h00100, 1'b1, 20'h00200, 1'b0, 6'h01);
        fill(20'h00300, 20'h00400, 1'b0, 6'h00);
        fill(20'hC0000, 20'h10000, 1'b1, 6'h01);
        op(1'b0, 1'b1, 1'b0, 20'h0, 20'h0, 1'b0, 6'h0, 20'h00100);
        look("R6", 20'h00100, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R6", 20'h00300, 1'b1, 20'h00400, 1'b0, 6'h00);
        op(1'b0, 1'b1, 1'b0, 20'h0, 20'h0, 1'b0, 6'h0, 20'hC03FF);
        look("R6", 20'hC0000, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R6", 20'h00300, 1'b1, 20'h00400, 1'b0, 6'h00);
    endtask

    // R7: overlapping fills replace rather than duplicate.
    task automatic t_overlap();
        fill(20'h55555, 20'h00001, 1'b0, 6'h00);
        fill(20'h55555, 20'h00002, 1'b0, 6'h04);
        look("R7", 20'h55555, 1'b1, 20'h00002, 1'b0, 6'h04);
        fill(20'h66001, 20'h11111, 1'b0, 6'h00);
        fill(20'h66003, 20'h33333, 1'b0, 6'h00);
        fill(20'h66000, 20'h22000, 1'b1, 6'h20);
        look("R7", 20'h66001, 1'b1, 20'h22001, 1'b1, 6'h20);
        look("R7", 20'h66003, 1'b1, 20'h22003, 1'b1, 6'h20);
    endtask

    // R8: fill ignored beside an invalidate or flush.
    task automatic t_priority();
        op(1'b1, 1'b1, 1'b0, 20'h77777, 20'h01234, 1'b0, 6'h00, 20'h00001);
        look("R8", 20'h77777, 1'b0, 20'h0, 1'b0, 6'h0);
        op(1'b1, 1'b0, 1'b1, 20'h77777, 20'h01234, 1'b0, 6'h01, 20'h0);
        look("R8", 20'h77777, 1'b0, 20'h0, 1'b0, 6'h0);
        fill(20'h77777, 20'h01234, 1'b0, 6'h00);
        look("R8", 20'h77777, 1'b1, 20'h01234, 1'b0, 6'h00);
    endtask

    // R9/R10: round-robin eviction when full; free slots first.
    task automatic t_replace();
        do_reset();
        for (int i = 0; i < 16; i++) fill(20'h10000 + 20'(i), 20'h50000 + 20'(i), 1'b0, 6'h00);
        look("R9", 20'h10000, 1'b1, 20'h50000, 1'b0, 6'h00);
        look("R9", 20'h1000F, 1'b1, 20'h5000F, 1'b0, 6'h00);
        fill(20'h20000, 20'h60000, 1'b0, 6'h00);
        look("R9", 20'h10000, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R9", 20'h10001, 1'b1, 20'h50001, 1'b0, 6'h00);
        look("R9", 20'h20000, 1'b1, 20'h60000, 1'b0, 6'h00);
        fill(20'h20001, 20'h60001, 1'b0, 6'h00);
        look("R9", 20'h10001, 1'b0, 20'h0, 1'b0, 6'h0);
        op(1'b0, 1'b1, 1'b0, 20'h0, 20'h0, 1'b0, 6'h0, 20'h10005);
        fill(20'h30000, 20'h70000, 1'b0, 6'h00);
        look("R10", 20'h10002, 1'b1, 20'h50002, 1'b0, 6'h00);
        look("R10", 20'h30000, 1'b1, 20'h70000, 1'b0, 6'h00);
        fill(20'h30001, 20'h70001, 1'b0, 6'h00);
        look("R9", 20'h10002, 1'b0, 20'h0, 1'b0, 6'h0);
        look("R9", 20'h10003, 1'b1, 20'h50003, 1'b0, 6'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_vpn = '0; fill_en = 1'b0; fill_vpn = '0; fill_pfn = '0;
        fill_large = 1'b0; fill_attr = '0; root_wr = 1'b0; inv_en = 1'b0; inv_vpn = '0;
        do_reset();
        t_reset();
        t_small();
        t_large();
        t_flush_inv();
        t_overlap();
        t_priority();
        t_replace();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule